// File: doc/BRIEF.md
# Timing-Step Shared-Bus Transfer Controller

This block is a small accumulator-style datapath in which five registers and a word-addressed memory exchange data over one shared bus. It has an address register, a program counter, a data register, an accumulator and an instruction register. A control decoder turns two one-hot timing pulses into a bus source code, per-register load and increment enables, and memory read and write strobes. Each timing step performs a fixed pair of transfers at a single clock edge. In the fetch step, the word that the address register points to is copied into the instruction register while the program counter advances. In the store step, the accumulator is written into memory at that same address while the data register advances.

When neither timing pulse is present, an external word can be steered onto the bus and loaded into any chosen set of registers. This is how surrounding control prepares addresses and operands between steps. The timing pulses always take precedence over the external path. If both pulses arrive together, the request is treated as invalid and nothing happens.

Top module: `bxc_top`

## Requirements
- R1: While rst_n is low, and after its release, every register (addr_q, pc_q, dr_q, ac_q, ir_q) reads zero until some transfer changes it.
- R2: With t0=1 and t1=0, the outputs are bus_sel=7 (memory), ld_en=5'b10000 (instruction register), inr_en=5'b00010 (program counter), mem_rd=1 and mem_wr=0. Enable vector bits are 0 address, 1 program counter, 2 data, 3 accumulator, 4 instruction.
- R3: At the edge that ends a t0-only cycle, ir_q takes the memory word at addr_q and pc_q becomes pc_q+1 modulo 2^16. All other registers hold.
- R4: With t1=1 and t0=0, the outputs are bus_sel=4 (accumulator), ld_en=0, inr_en=5'b00100 (data register), mem_rd=0 and mem_wr=1.
- R5: At the edge that ends a t1-only cycle, the memory word at addr_q becomes ac_q and dr_q becomes dr_q+1 modulo 2^16. All other registers hold.
- R6: With t0=0, t1=0 and ext_ld=0, the outputs are bus_sel=0, bus_word=0, all enables zero and both strobes low, and every register holds.
- R7: With t0=0, t1=0 and ext_ld nonzero, bus_sel=6 and bus_word=ext_word. Each register whose ext_ld bit is set loads the bus. The address register takes the low 12 bits. Both memory strobes stay low.
- R8: When t0 or t1 is active, ext_ld has no effect on the controls or on any register.
- R9: With t0=1 and t1=1 together, all enables and strobes are zero, bus_sel=0, and every register and memory word holds.
- R10: bus_word always equals the source named by bus_sel. For code 7 this is the memory word at addr_q, readable within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the registers |
| t0 | input | 1 | Fetch timing pulse |
| t1 | input | 1 | Store timing pulse |
| ext_ld | input | 5 | Per-register external load request, used only when no timing pulse is active |
| ext_word | input | 16 | Word driven onto the bus for external loads |
| bus_sel | output | 3 | Bus source code |
| ld_en | output | 5 | Register load enables |
| inr_en | output | 5 | Register increment enables |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| bus_word | output | 16 | Current shared bus value |
| addr_q | output | 12 | Address register |
| pc_q | output | 16 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |

## Verification
A decoder fault appears at once, in the same cycle as the timing pulse, as a wrong bus code, enable set or strobe. A wrong register update appears on the register outputs one edge later. A corrupted memory word or a write to the wrong address stays hidden until a later fetch step reads that location into the instruction register. For this reason the stimulus reads back stored addresses often, and it reuses addresses after the address register has been reloaded.

// File: rtl/bxc_pkg.sv
package bxc_pkg;

    localparam int NUM_REGS = 5;
    localparam int IDX_AR   = 0;
    localparam int IDX_PC   = 1;
    localparam int IDX_DR   = 2;
    localparam int IDX_AC   = 3;
    localparam int IDX_IR   = 4;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_AR   = 3'd1,
        SEL_PC   = 3'd2,
        SEL_DR   = 3'd3,
        SEL_AC   = 3'd4,
        SEL_IR   = 3'd5,
        SEL_EXT  = 3'd6,
        SEL_MEM  = 3'd7
    } bus_sel_e;

    typedef struct packed {
        bus_sel_e              sel;
        logic [NUM_REGS-1:0]   ld;
        logic [NUM_REGS-1:0]   inr;
        logic                  rd;
        logic                  wr;
    } ctrl_t;

endpackage

// File: rtl/bxc_ctrl.sv
module bxc_ctrl
    import bxc_pkg::*;
(
    input  logic                t0,
    input  logic                t1,
    input  logic [NUM_REGS-1:0] ext_ld,
    output ctrl_t               ctrl
);

    always_comb begin
        ctrl     = '0;
        ctrl.sel = SEL_NONE;
        unique case ({t1, t0})
            2'b01: begin
                ctrl.sel         = SEL_MEM;
                ctrl.ld[IDX_IR]  = 1'b1;
                ctrl.inr[IDX_PC] = 1'b1;
                ctrl.rd          = 1'b1;
            end
            2'b10: begin
                ctrl.sel         = SEL_AC;
                ctrl.inr[IDX_DR] = 1'b1;
                ctrl.wr          = 1'b1;
            end
            2'b00: begin
                if (ext_ld != '0) begin
                    ctrl.sel = SEL_EXT;
                    ctrl.ld  = ext_ld;
                end
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/bxc_bus.sv
module bxc_bus
    import bxc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  bus_sel_e           sel,
    input  logic [ADDR_W-1:0]  ar,
    input  logic [DATA_W-1:0]  pc,
    input  logic [DATA_W-1:0]  dr,
    input  logic [DATA_W-1:0]  ac,
    input  logic [DATA_W-1:0]  ir,
    input  logic [DATA_W-1:0]  ext,
    input  logic [DATA_W-1:0]  mem,
    output logic [DATA_W-1:0]  bus
);

    localparam int PAD_W = DATA_W - ADDR_W;

    always_comb begin
        unique case (sel)
            SEL_AR:  bus = {{PAD_W{1'b0}}, ar};
            SEL_PC:  bus = pc;
            SEL_DR:  bus = dr;
            SEL_AC:  bus = ac;
            SEL_IR:  bus = ir;
            SEL_EXT: bus = ext;
            SEL_MEM: bus = mem;
            default: bus = '0;
        endcase
    end

endmodule

// File: rtl/bxc_mem.sv
module bxc_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic               clk,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[addr] <= wdata;
        end
    end

    assign rdata = store_q[addr];

endmodule

// File: rtl/bxc_top.sv
module bxc_top
    import bxc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 t0,
    input  logic                 t1,
    input  logic [NUM_REGS-1:0]  ext_ld,
    input  logic [DATA_W-1:0]    ext_word,
    output logic [2:0]           bus_sel,
    output logic [NUM_REGS-1:0]  ld_en,
    output logic [NUM_REGS-1:0]  inr_en,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic [DATA_W-1:0]    bus_word,
    output logic [ADDR_W-1:0]    addr_q,
    output logic [DATA_W-1:0]    pc_q,
    output logic [DATA_W-1:0]    dr_q,
    output logic [DATA_W-1:0]    ac_q,
    output logic [DATA_W-1:0]    ir_q
);

    typedef struct packed {
        logic [ADDR_W-1:0] ar;
        logic [DATA_W-1:0] pc;
        logic [DATA_W-1:0] dr;
        logic [DATA_W-1:0] ac;
        logic [DATA_W-1:0] ir;
    } regs_t;

    ctrl_t             ctrl;
    regs_t             regs_d;
    regs_t             regs_q;
    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] bus;

    bxc_ctrl u_ctrl (
        .t0     (t0),
        .t1     (t1),
        .ext_ld (ext_ld),
        .ctrl   (ctrl)
    );

    bxc_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (ctrl.wr),
        .addr  (regs_q.ar),
        .wdata (bus),
        .rdata (mem_rdata)
    );

    bxc_bus #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
        .sel (ctrl.sel),
        .ar  (regs_q.ar),
        .pc  (regs_q.pc),
        .dr  (regs_q.dr),
        .ac  (regs_q.ac),
        .ir  (regs_q.ir),
        .ext (ext_word),
        .mem (mem_rdata),
        .bus (bus)
    );

    // Next-state: load from the bus wins over increment; otherwise hold.
    always_comb begin
        regs_d = regs_q;
        if (ctrl.ld[IDX_AR])       regs_d.ar = bus[ADDR_W-1:0];
        else if (ctrl.inr[IDX_AR]) regs_d.ar = regs_q.ar + 1'b1;
        if (ctrl.ld[IDX_PC])       regs_d.pc = bus;
        else if (ctrl.inr[IDX_PC]) regs_d.pc = regs_q.pc + 1'b1;
        if (ctrl.ld[IDX_DR])       regs_d.dr = bus;
        else if (ctrl.inr[IDX_DR]) regs_d.dr = regs_q.dr + 1'b1;
        if (ctrl.ld[IDX_AC])       regs_d.ac = bus;
        else if (ctrl.inr[IDX_AC]) regs_d.ac = regs_q.ac + 1'b1;
        if (ctrl.ld[IDX_IR])       regs_d.ir = bus;
        else if (ctrl.inr[IDX_IR]) regs_d.ir = regs_q.ir + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bus_sel  = ctrl.sel;
    assign ld_en    = ctrl.ld;
    assign inr_en   = ctrl.inr;
    assign mem_rd   = ctrl.rd;
    assign mem_wr   = ctrl.wr;
    assign bus_word = bus;
    assign addr_q   = regs_q.ar;
    assign pc_q     = regs_q.pc;
    assign dr_q     = regs_q.dr;
    assign ac_q     = regs_q.ac;
    assign ir_q     = regs_q.ir;

endmodule

// File: rtl/bxc_top_chk.sv
module bxc_top_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               t0,
    input logic               t1,
    input logic [4:0]         ext_ld,
    input logic [DATA_W-1:0]  ext_word,
    input logic [2:0]         bus_sel,
    input logic [4:0]         ld_en,
    input logic [4:0]         inr_en,
    input logic               mem_rd,
    input logic               mem_wr,
    input logic [DATA_W-1:0]  bus_word,
    input logic [ADDR_W-1:0]  addr_q,
    input logic [DATA_W-1:0]  pc_q,
    input logic [DATA_W-1:0]  dr_q,
    input logic [DATA_W-1:0]  ac_q,
    input logic [DATA_W-1:0]  ir_q
);

    a_r2_fetch_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (t0 && !t1) |-> (bus_sel == 3'd7 && ld_en == 5'b10000 &&
                         inr_en == 5'b00010 && mem_rd && !mem_wr));

    a_r3_fetch_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (t0 && !t1) |=> (ir_q == $past(bus_word) && pc_q == $past(pc_q) + 1'b1 &&
                         $stable(dr_q) && $stable(ac_q) && $stable(addr_q)));

    a_r4_store_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (t1 && !t0) |-> (bus_sel == 3'd4 && ld_en == 5'b0 &&
                         inr_en == 5'b00100 && mem_wr && !mem_rd));

    a_r5_store_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (t1 && !t0) |=> (dr_q == $past(dr_q) + 1'b1 && $stable(pc_q) &&
                         $stable(ir_q) && $stable(ac_q) && $stable(addr_q)));

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!t0 && !t1 && ext_ld == 5'b0) |=> ($stable(addr_q) && $stable(pc_q) &&
                         $stable(dr_q) && $stable(ac_q) && $stable(ir_q)));

    a_r7_ext_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (!t0 && !t1 && ext_ld != 5'b0) |-> (bus_word == ext_word && !mem_rd && !mem_wr));

    a_r9_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        (t0 && t1) |-> (ld_en == 5'b0 && inr_en == 5'b0 && !mem_rd && !mem_wr &&
                        bus_sel == 3'd0));

    a_r10_strobes_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

endmodule

bind bxc_top bxc_top_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .t0       (t0),
    .t1       (t1),
    .ext_ld   (ext_ld),
    .ext_word (ext_word),
    .bus_sel  (bus_sel),
    .ld_en    (ld_en),
    .inr_en   (inr_en),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .bus_word (bus_word),
    .addr_q   (addr_q),
    .pc_q     (pc_q),
    .dr_q     (dr_q),
    .ac_q     (ac_q),
    .ir_q     (ir_q)
);

// File: tb/bxc_top_tb.sv
module bxc_top_tb;

    localparam int DW    = 16;
    localparam int AW    = 12;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          t0 = 1'b0;
    logic          t1 = 1'b0;
    logic [4:0]    ext_ld = '0;
    logic [DW-1:0] ext_word = '0;
    logic [2:0]    bus_sel;
    logic [4:0]    ld_en;
    logic [4:0]    inr_en;
    logic          mem_rd;
    logic          mem_wr;
    logic [DW-1:0] bus_word;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] pc_q, dr_q, ac_q, ir_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model
    logic [AW-1:0] m_ar;
    logic [DW-1:0] m_pc, m_dr, m_ac, m_ir;
    logic [DW-1:0] m_mem [DEPTH];
    bit            m_ok  [DEPTH];

    always #5 clk = ~clk;

    bxc_top u_dut (
        .clk(clk), .rst_n(rst_n), .t0(t0), .t1(t1),
        .ext_ld(ext_ld), .ext_word(ext_word),
        .bus_sel(bus_sel), .ld_en(ld_en), .inr_en(inr_en),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .bus_word(bus_word),
        .addr_q(addr_q), .pc_q(pc_q), .dr_q(dr_q), .ac_q(ac_q), .ir_q(ir_q)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string step_tag(input logic a0, input logic a1, input logic [4:0] el);
        if (a0 && a1)              return "R9";
        if ((a0 || a1) && el != 0) return "R8";
        if (a0)                    return "R3";
        if (a1)                    return "R5";
        if (el != 0)               return "R7";
        return "R6";
    endfunction

    function automatic string ctrl_tag(input logic a0, input logic a1, input logic [4:0] el);
        if (a0 && a1)              return "R9";
        if ((a0 || a1) && el != 0) return "R8";
        if (a0)                    return "R2";
        if (a1)                    return "R4";
        if (el != 0)               return "R7";
        return "R6";
    endfunction

    task automatic check_regs(input string tag);
        chk(addr_q == m_ar, tag, "addr_q", 32'(addr_q), 32'(m_ar));
        chk(pc_q == m_pc,   tag, "pc_q",   32'(pc_q),   32'(m_pc));
        chk(dr_q == m_dr,   tag, "dr_q",   32'(dr_q),   32'(m_dr));
        chk(ac_q == m_ac,   tag, "ac_q",   32'(ac_q),   32'(m_ac));
        chk(ir_q == m_ir,   tag, "ir_q",   32'(ir_q),   32'(m_ir));
    endtask

    task automatic step(input logic a0, input logic a1, input logic [4:0] el,
                        input logic [DW-1:0] ew);
        logic [2:0]    e_sel;
        logic [4:0]    e_ld, e_inr;
        logic          e_rd, e_wr;
        logic [DW-1:0] e_bus;
        string         ct, st;
        @(negedge clk);
        t0 = a0; t1 = a1; ext_ld = el; ext_word = ew;
        #1;
        ct = ctrl_tag(a0, a1, el);
        st = step_tag(a0, a1, el);
        e_sel = 3'd0; e_ld = '0; e_inr = '0; e_rd = 1'b0; e_wr = 1'b0;
        case ({a1, a0})
            2'b01: begin e_sel = 3'd7; e_ld = 5'b10000; e_inr = 5'b00010; e_rd = 1'b1; end
            2'b10: begin e_sel = 3'd4; e_inr = 5'b00100; e_wr = 1'b1; end
            2'b00: if (el != 0) begin e_sel = 3'd6; e_ld = el; end
            default: ;
        endcase
        case (e_sel)
            3'd7:    e_bus = m_mem[m_ar];
            3'd4:    e_bus = m_ac;
            3'd6:    e_bus = ew;
            default: e_bus = '0;
        endcase
        chk(bus_sel == e_sel, ct, "bus_sel", 32'(bus_sel), 32'(e_sel));
        chk(ld_en == e_ld,    ct, "ld_en",   32'(ld_en),   32'(e_ld));
        chk(inr_en == e_inr,  ct, "inr_en",  32'(inr_en),  32'(e_inr));
        chk(mem_rd == e_rd,   ct, "mem_rd",  32'(mem_rd),  32'(e_rd));
        chk(mem_wr == e_wr,   ct, "mem_wr",  32'(mem_wr),  32'(e_wr));
        chk(bus_word == e_bus, "R10", "bus_word", 32'(bus_word), 32'(e_bus));
        // model update
        if (e_wr) begin m_mem[m_ar] = e_bus; m_ok[m_ar] = 1'b1; end
        if (e_ld[4]) m_ir = e_bus;
        if (e_ld[3]) m_ac = e_bus;
        if (e_ld[2]) m_dr = e_bus;
        if (e_ld[1]) m_pc = e_bus;
        if (e_ld[0]) m_ar = e_bus[AW-1:0];
        if (e_inr[1]) m_pc = m_pc + 1'b1;
        if (e_inr[2]) m_dr = m_dr + 1'b1;
        @(posedge clk);
        #1;
        check_regs(st);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_ar = '0; m_pc = '0; m_dr = '0; m_ac = '0; m_ir = '0;
        for (int i = 0; i < DEPTH; i++) begin m_mem[i] = '0; m_ok[i] = 1'b0; end
        repeat (3) @(posedge clk);
        #1;
        check_regs("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_regs("R1");

        // Directed: address truncation to 12 bits (R7)
        step(1'b0, 1'b0, 5'b00001, 16'hF123);
        chk(addr_q == 12'h123, "R7", "addr low bits", 32'(addr_q), 32'h123);
        // Store accumulator, then fetch it back (R5, R3)
        step(1'b0, 1'b0, 5'b01000, 16'hBEEF);
        step(1'b0, 1'b1, 5'b00000, 16'h0);
        step(1'b1, 1'b0, 5'b00000, 16'h0);
        chk(ir_q == 16'hBEEF, "R3", "ir after fetch", 32'(ir_q), 32'hBEEF);
        // Program counter and data register wrap (R3, R5)
        step(1'b0, 1'b0, 5'b00110, 16'hFFFF);
        step(1'b1, 1'b0, 5'b00000, 16'h0);
        chk(pc_q == 16'h0000, "R3", "pc wrap", 32'(pc_q), 32'h0);
        step(1'b0, 1'b1, 5'b00000, 16'h0);
        chk(dr_q == 16'h0000, "R5", "dr wrap", 32'(dr_q), 32'h0);
        // External request ignored under timing pulses (R8), conflict (R9), idle (R6)
        step(1'b1, 1'b0, 5'b11111, 16'h1357);
        step(1'b0, 1'b1, 5'b11111, 16'h2468);
        step(1'b1, 1'b1, 5'b11111, 16'h9999);
        step(1'b1, 1'b1, 5'b00000, 16'h0);
        step(1'b0, 1'b0, 5'b00000, 16'hABCD);

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int unsigned kind;
            logic [4:0]  el;
            logic [DW-1:0] ew;
            kind = $urandom % 10;
            el   = 5'($urandom);
            ew   = 16'($urandom);
            if (kind < 2) begin
                el = (kind == 0) ? 5'b00001 : el;
                ew = (kind == 0) ? 16'($urandom % 16) : ew;
                if (el == 0) el = 5'b01000;
                step(1'b0, 1'b0, el, ew);
            end else if (kind < 5) begin
                step(1'b0, 1'b1, ($urandom % 3 == 0) ? el : 5'b0, ew);
            end else if (kind < 8) begin
                if (m_ok[m_ar]) step(1'b1, 1'b0, ($urandom % 3 == 0) ? el : 5'b0, ew);
                else            step(1'b0, 1'b1, 5'b0, ew);
            end else if (kind == 8) begin
                step(1'b1, 1'b1, el, ew);
            end else begin
                step(1'b0, 1'b0, 5'b0, ew);
            end
        end

        @(negedge clk);
        t0 = 1'b0; t1 = 1'b0; ext_ld = '0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule